// File: doc/BRIEF.md
# Comm Board Control Register File

This block is the small register file that a communication board's local processor reaches over a 16-bit memory-mapped I/O path. It holds four transfer descriptors: receive offset, receive size, send offset and send size. It also holds two status words for exchange with the host side. A trigger register per direction raises an interrupt toward the local processor, and a control register holds that processor in reset or lets it run. A separate one-register port picks which 64 KB half of a 128 KB shared RAM is visible through the board's window.

Descriptors are filled one byte at a time. Each write moves the new byte into the upper half and the previous upper half into the lower half, so two successive byte writes build a 16-bit value. A trigger fires only on one exact code in the low byte; any other write to the trigger clears the interrupt.

Two state machines carry the control state:
- Each trigger instance has the states `TRIG_IDLE` and `TRIG_RAISED`. The transition *arm* (trigger write with low byte 0x8C) goes from `TRIG_IDLE` to `TRIG_RAISED`. The transition *disarm* (trigger write with any other low byte) returns to `TRIG_IDLE`. Every other cycle holds the state.
- The processor reset controller has the states `PROC_HELD` and `PROC_RUN`. The transition *release* (control write of nonzero data) enters `PROC_RUN`. The transition *hold* (control write of zero) enters `PROC_HELD`. System reset lands in `PROC_HELD`.

Top module: `comm_ctrl_regs`

## Requirements
- R1: After reset every status word, every descriptor and the bank register read as zero, both interrupts are low, `bank_upper` is low and `proc_reset` is high.
- R2: Status word 0 at byte offset 0x88 and status word 1 at byte offset 0x8A each store all 16 written bits and read them back; writing one leaves the other unchanged.
- R3: Descriptors live at 0x40 (receive offset), 0x42 (receive size), 0x44 (send offset) and 0x46 (send size). A write sets the addressed one to {wdata[7:0], previous bits [15:8]}. Bits [15:8] of the written data are ignored, and the other descriptors keep their values.
- R4: A write to 0x16 whose low byte is 0x8C sets `rx_irq` from the next cycle. Any other low byte clears it, bits [15:8] of the data are ignored, and `rx_irq` holds between writes.
- R5: A write to 0x1C whose low byte is 0x8C sets `tx_irq` from the next cycle. Any other low byte clears it, bits [15:8] of the data are ignored, and `tx_irq` holds between writes.
- R6: A write to 0xC0 with nonzero data drives `proc_reset` low from the next cycle. Zero data drives it high.
- R7: A bank write stores all 16 bits, which read back on `bank_rdata`. `bank_upper` is high exactly when the stored value is nonzero.
- R8: Reads of any offset other than the status and descriptor offsets return zero, including the trigger and control offsets, which are write-only. Writes to offsets with no register, odd offsets among them, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_wr | input | 1 | Register write strobe |
| io_addr | input | 8 | Byte offset of the access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data for io_addr (combinational) |
| bank_wr | input | 1 | Bank register write strobe |
| bank_wdata | input | 16 | Bank register write data |
| bank_rdata | output | 16 | Bank register contents |
| bank_upper | output | 1 | High selects the upper 64 KB half of shared RAM |
| rx_irq | output | 1 | Receive interrupt level toward the local processor |
| tx_irq | output | 1 | Send interrupt level toward the local processor |
| proc_reset | output | 1 | High holds the local processor in reset |

## Verification
The bench builds the block with its defaults: a 16-bit data path, an 8-bit offset and a trigger code of 0x8C. The 8-bit offset puts every byte offset from 0x00 to 0xFF within reach. That includes the odd neighbours of mapped registers, so the bench can show that decode matches the whole offset and not only its upper bits. The 16-bit width lets the bench place a nonzero upper byte next to the trigger code, and so show that only the low byte arms or disarms an interrupt and only the low byte enters a descriptor.

// File: rtl/comm_regs_pkg.sv
package comm_regs_pkg;
    localparam logic [7:0] OFF_RX_TRIG = 8'h16;
    localparam logic [7:0] OFF_TX_TRIG = 8'h1C;
    localparam logic [7:0] OFF_DESC0   = 8'h40;
    localparam logic [7:0] OFF_STAT0   = 8'h88;
    localparam logic [7:0] OFF_STAT1   = 8'h8A;
    localparam logic [7:0] OFF_PCTL    = 8'hC0;
    localparam int         NUM_DESC    = 4;

    typedef enum logic {TRIG_IDLE, TRIG_RAISED} trig_state_e;
    typedef enum logic {PROC_HELD, PROC_RUN}    proc_state_e;
endpackage

// File: rtl/desc_shift_reg.sv
module desc_shift_reg #(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [DATA_W/2-1:0] byte_in,
    output logic [DATA_W-1:0]   q
);
    localparam int HALF_W = DATA_W / 2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (wr) q <= {byte_in, q[DATA_W-1:HALF_W]};
    end

    // R3
    desc_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (q[DATA_W-1:HALF_W] == $past(byte_in)) &&
               (q[HALF_W-1:0] == $past(q[DATA_W-1:HALF_W])));
endmodule

// File: rtl/irq_trigger.sv
module irq_trigger #(
    parameter logic [7:0] TRIG_CODE = 8'h8C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] code,
    output logic       irq
);
    import comm_regs_pkg::*;

    trig_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRIG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRIG_IDLE:   if (wr && code == TRIG_CODE) state_d = TRIG_RAISED;
            TRIG_RAISED: if (wr && code != TRIG_CODE) state_d = TRIG_IDLE;
            default:     state_d = TRIG_IDLE;
        endcase
    end

    always_comb irq = (state_q == TRIG_RAISED);

    // R4 R5
    trig_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && code == TRIG_CODE) |=> irq);
    // R4 R5
    trig_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && code != TRIG_CODE) |=> !irq);
    // R4 R5
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(irq));
endmodule

// File: rtl/proc_reset_ctl.sv
module proc_reset_ctl #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    output logic              proc_reset
);
    import comm_regs_pkg::*;

    proc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PROC_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PROC_HELD: if (wr && (|data))  state_d = PROC_RUN;
            PROC_RUN:  if (wr && !(|data)) state_d = PROC_HELD;
            default:   state_d = PROC_HELD;
        endcase
    end

    always_comb proc_reset = (state_q == PROC_HELD);

    // R6
    proc_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && data != '0) |=> !proc_reset);
    // R6
    proc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && data == '0) |=> proc_reset);
endmodule

// File: rtl/comm_ctrl_regs.sv
module comm_ctrl_regs #(
    parameter int         DATA_W    = 16,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] TRIG_CODE = 8'h8C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              bank_wr,
    input  logic [DATA_W-1:0] bank_wdata,
    output logic [DATA_W-1:0] bank_rdata,
    output logic              bank_upper,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              proc_reset
);
    import comm_regs_pkg::*;

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] stat0_q, stat1_q, bank_q;
    logic [DATA_W-1:0] desc_q [NUM_DESC];
    logic [NUM_DESC-1:0] desc_hit;
    logic hit_stat0, hit_stat1, hit_rx, hit_tx, hit_pctl, mapped_wr;

    always_comb begin
        hit_stat0 = (io_addr == ADDR_W'(OFF_STAT0));
        hit_stat1 = (io_addr == ADDR_W'(OFF_STAT1));
        hit_rx    = (io_addr == ADDR_W'(OFF_RX_TRIG));
        hit_tx    = (io_addr == ADDR_W'(OFF_TX_TRIG));
        hit_pctl  = (io_addr == ADDR_W'(OFF_PCTL));
        mapped_wr = hit_stat0 | hit_stat1 | hit_rx | hit_tx | hit_pctl | (|desc_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat0_q <= '0;
            stat1_q <= '0;
            bank_q  <= '0;
        end else begin
            if (io_wr && hit_stat0) stat0_q <= io_wdata;
            if (io_wr && hit_stat1) stat1_q <= io_wdata;
            if (bank_wr)            bank_q  <= bank_wdata;
        end
    end

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_desc
        always_comb desc_hit[i] = (io_addr == ADDR_W'(OFF_DESC0 + 8'(2 * i)));
        desc_shift_reg #(.DATA_W(DATA_W)) u_desc (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr      (io_wr && desc_hit[i]),
            .byte_in (io_wdata[HALF_W-1:0]),
            .q       (desc_q[i])
        );
    end

    irq_trigger #(.TRIG_CODE(TRIG_CODE)) u_rx_trig (
        .clk (clk), .rst_n (rst_n), .wr (io_wr && hit_rx),
        .code (io_wdata[7:0]), .irq (rx_irq)
    );
    irq_trigger #(.TRIG_CODE(TRIG_CODE)) u_tx_trig (
        .clk (clk), .rst_n (rst_n), .wr (io_wr && hit_tx),
        .code (io_wdata[7:0]), .irq (tx_irq)
    );
    proc_reset_ctl #(.DATA_W(DATA_W)) u_pctl (
        .clk (clk), .rst_n (rst_n), .wr (io_wr && hit_pctl),
        .data (io_wdata), .proc_reset (proc_reset)
    );

    always_comb begin
        io_rdata = '0;
        if (hit_stat0)      io_rdata = stat0_q;
        else if (hit_stat1) io_rdata = stat1_q;
        else begin
            for (int i = 0; i < NUM_DESC; i++)
                if (desc_hit[i]) io_rdata = desc_q[i];
        end
    end

    always_comb begin
        bank_rdata = bank_q;
        bank_upper = |bank_q;
    end

    // R2
    stat0_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_stat0) |=> stat0_q == $past(io_wdata));
    // R2
    stat1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && hit_stat0) |=> $stable(stat1_q));
    // R7
    bank_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> bank_rdata == $past(bank_wdata));
    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !mapped_wr) |=> $stable(stat0_q) && $stable(stat1_q) &&
            $stable(rx_irq) && $stable(tx_irq) && $stable(proc_reset) &&
            $stable(desc_q[0]) && $stable(desc_q[3]));
endmodule

// File: tb/tb_comm_ctrl_regs.sv
`timescale 1ns/1ps
module tb_comm_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        bank_wr = 1'b0;
    logic [15:0] bank_wdata = '0;
    logic [15:0] bank_rdata;
    logic        bank_upper, rx_irq, tx_irq, proc_reset;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    comm_ctrl_regs dut (
        .clk (clk), .rst_n (rst_n), .io_wr (io_wr), .io_addr (io_addr),
        .io_wdata (io_wdata), .io_rdata (io_rdata), .bank_wr (bank_wr),
        .bank_wdata (bank_wdata), .bank_rdata (bank_rdata),
        .bank_upper (bank_upper), .rx_irq (rx_irq), .tx_irq (tx_irq),
        .proc_reset (proc_reset)
    );

    // {write offset, write data, read offset, expected read data}
    localparam int NVEC = 14;
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h88, 16'hA5A5, 8'h88, 16'hA5A5},
        {8'h8A, 16'h1234, 8'h8A, 16'h1234},
        {8'h8A, 16'h5A5A, 8'h88, 16'hA5A5},
        {8'h40, 16'h0034, 8'h40, 16'h3400},
        {8'h40, 16'hFF12, 8'h40, 16'h1234},
        {8'h42, 16'h00CD, 8'h42, 16'hCD00},
        {8'h42, 16'h00AB, 8'h42, 16'hABCD},
        {8'h44, 16'h0077, 8'h40, 16'h1234},
        {8'h46, 16'h0011, 8'h46, 16'h1100},
        {8'h44, 16'h0066, 8'h44, 16'h6677},
        {8'h30, 16'hFFFF, 8'h30, 16'h0000},
        {8'h31, 16'hFFFF, 8'h88, 16'hA5A5},
        {8'h41, 16'h00EE, 8'h40, 16'h1234},
        {8'h16, 16'h008C, 8'h16, 16'h0000}
    };

    function automatic string vec_req(int idx);
        if (idx < 3)       return "R2";
        else if (idx < 10) return "R3";
        else               return "R8";
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic io_write(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(logic [7:0] a, output logic [15:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic bank_write(logic [15:0] d);
        @(negedge clk);
        bank_wr = 1'b1; bank_wdata = d;
        @(negedge clk);
        bank_wr = 1'b0;
    endtask

    task automatic check_reset_state();
        logic [15:0] r;
        io_read(8'h88, r); check("R1", r, 16'h0);
        io_read(8'h8A, r); check("R1", r, 16'h0);
        for (int i = 0; i < 4; i++) begin
            io_read(8'h40 + 8'(2 * i), r); check("R1", r, 16'h0);
        end
        check("R1", bank_rdata, 16'h0);
        check("R1", {13'b0, bank_upper, rx_irq, tx_irq}, 16'h0);
        check("R1", {15'b0, proc_reset}, 16'h1);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state(); // R1

        for (int i = 0; i < NVEC; i++) begin
            io_write(VEC[i][47:40], VEC[i][39:24]);
            io_read(VEC[i][23:16], r);
            check(vec_req(i), r, VEC[i][15:0]);
        end

        // R4: last vector armed the receive trigger
        check("R4", {15'b0, rx_irq}, 16'h1);
        check("R5", {15'b0, tx_irq}, 16'h0);
        io_write(8'h16, 16'h8C42);  // code in upper byte only: disarms
        check("R4", {15'b0, rx_irq}, 16'h0);
        io_write(8'h16, 16'h118C);  // upper byte ignored: arms
        check("R4", {15'b0, rx_irq}, 16'h1);
        repeat (4) @(negedge clk);
        check("R4", {15'b0, rx_irq}, 16'h1);
        io_write(8'h17, 16'h0000);  // odd neighbour unmapped (R8)
        check("R8", {15'b0, rx_irq}, 16'h1);

        // R5
        io_write(8'h1C, 16'h008C);
        check("R5", {15'b0, tx_irq}, 16'h1);
        check("R5", {15'b0, rx_irq}, 16'h1);
        io_write(8'h1C, 16'h008D);
        check("R5", {15'b0, tx_irq}, 16'h0);
        io_write(8'h1C, 16'hFF8C);
        check("R5", {15'b0, tx_irq}, 16'h1);

        // R6
        io_write(8'hC0, 16'h0001);
        check("R6", {15'b0, proc_reset}, 16'h0);
        io_write(8'hC0, 16'h0000);
        check("R6", {15'b0, proc_reset}, 16'h1);
        io_write(8'hC0, 16'h0100);
        check("R6", {15'b0, proc_reset}, 16'h0);
        io_write(8'hC1, 16'h0000);  // R8: unmapped, no effect
        check("R8", {15'b0, proc_reset}, 16'h0);
        io_read(8'hC0, r);
        check("R8", r, 16'h0);

        // R7
        bank_write(16'h0002);
        check("R7", bank_rdata, 16'h0002);
        check("R7", {15'b0, bank_upper}, 16'h1);
        bank_write(16'h0000);
        check("R7", {15'b0, bank_upper}, 16'h0);
        bank_write(16'h8000);
        check("R7", {15'b0, bank_upper}, 16'h1);

        // R1: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule